// File: doc/BRIEF.md
# Matched-Filter Tap Processing Element

This block is one processing element of an azimuth matched filter. It is dedicated to a single fixed tap position in that filter. For every range-compressed sample accepted inside a range column, it emits one partial product term to a downstream cascade adder. It holds two small memories, both addressed cyclically. The first is a coefficient store with one group of interpolation weights per range segment. The second is a sample ring buffer that absorbs the range-cell-migration offset.

The migration offset rises monotonically along the column. A fixed-point accumulator adds a configured step after every accepted sample. The integer part of that accumulator is subtracted from the ring write position to form the buffer read address. The term is a four-tap interpolation: the sum of four products of coefficients and consecutive buffer entries, counted backwards from the offset slot. The coefficient group advances every 64 samples. After the last group the column ends.

A two-state controller sequences the work. In `ST_IDLE` samples are ignored and coefficients may be written. The START transition (`col_start`) moves to `ST_RUN`. In `ST_RUN` samples are processed and coefficient writes are blocked. The RESTART transition (`col_start` again) stays in `ST_RUN` and clears the column counters. The END transition (the last sample of the column) returns to `ST_IDLE`.

Top module: `mf_tap_pe`

## Requirements
- R1: After reset, `res_valid` is 0, `res_data` is 0, the ring buffer and every coefficient are 0, and the controller is in `ST_IDLE`.
- R2: A cycle with `col_start` high clears the sample count, the group index and the offset accumulator, latches `step_cfg`, and enters `ST_RUN` from either state. A sample presented in that same cycle is dropped.
- R3: Each accepted sample (`smp_valid` high in `ST_RUN` without `col_start`) gives exactly one `res_valid` pulse. The pulse is registered by the second rising edge after the edge that captures the sample.
- R4: The result equals the sum over k = 0..3 of C[g][k] * B[(w - off - k) mod 16], as a 34-bit signed value. Here w is the ring slot written by the current sample, B is the ring content including that sample, off is the current offset and g is the current group.
- R5: The ring write slot advances by one per accepted sample, modulo 16. It is not reset by `col_start`, so taps may reach samples from the previous column.
- R6: The offset equals floor(acc / 256) mod 16. `acc` is 12 bits wide, starts at 0 for the first sample of a column and adds the 12-bit unsigned step after each accepted sample (8 fractional bits).
- R7: The group index is the sample number within the column divided by 64, so 0..3. Coefficient address bits [3:2] select the group and bits [1:0] select the tap k.
- R8: After the 256th accepted sample the controller returns to `ST_IDLE`. Samples offered in `ST_IDLE` produce no result and are not written into the ring.
- R9: Coefficient writes take effect only in `ST_IDLE`. Writes in `ST_RUN` leave the store unchanged.
- R10: Changes of `step_cfg` during a column have no effect until the next `col_start`.
- R11: While `res_valid` is low, `res_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_start | input | 1 | Begin (or restart) a range column |
| step_cfg | input | 12 | Migration offset step, 8 fractional bits |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed range-compressed sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Coefficient address {group, tap} |
| coef_data | input | 16 | Signed coefficient |
| res_valid | output | 1 | Result strobe |
| res_data | output | 34 | Signed inner-sum term |

## Verification
Suppose the ring write slot or the offset accumulator goes wrong. The very next result then reads the wrong entries, and the error shows in `res_data` two edges after the capture. A wrong group index stays hidden until a 64-sample boundary, when the term uses the wrong weights. A controller that leaves `ST_RUN` early or late shows up as missing or extra `res_valid` pulses at the column end. Bad gating of writes or of the step only shows in later terms. So the stimulus writes a late-group coefficient in the first group, changes the step early in a column, and checks every term that follows.

// File: rtl/mf_pe_pkg.sv
package mf_pe_pkg;

    localparam int DEF_DW       = 16;
    localparam int DEF_CW       = 16;
    localparam int DEF_TAPS     = 4;
    localparam int DEF_DEPTH    = 16;
    localparam int DEF_SEG_LEN  = 64;
    localparam int DEF_NUM_SETS = 4;
    localparam int DEF_FRAC     = 8;
    localparam int DEF_STEP_W   = 12;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pe_state_t;

endpackage

// File: rtl/mf_pe_ctrl.sv
module mf_pe_ctrl
    import mf_pe_pkg::*;
#(
    parameter int SEG_LEN  = DEF_SEG_LEN,
    parameter int NUM_SETS = DEF_NUM_SETS,
    parameter int FRAC     = DEF_FRAC,
    parameter int STEP_W   = DEF_STEP_W,
    parameter int AW       = 4,
    localparam int SW      = $clog2(NUM_SETS),
    localparam int GW      = $clog2(SEG_LEN),
    localparam int ACC_W   = AW + FRAC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              col_start,
    input  logic              smp_valid,
    input  logic [STEP_W-1:0] step_cfg,
    output logic              smp_acc,
    output logic              busy,
    output logic [SW-1:0]     set_idx,
    output logic [AW-1:0]     rd_off
);

    pe_state_t         state_q, state_d;
    logic [GW-1:0]     seg_q;
    logic [SW-1:0]     set_q;
    logic [ACC_W-1:0]  acc_q;
    logic [STEP_W-1:0] step_q;
    logic              col_last;

    assign col_last = (set_q == SW'(NUM_SETS - 1)) && (seg_q == GW'(SEG_LEN - 1));

    // next-state logic: START, RESTART, END
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (col_start) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (col_start)                   state_d = ST_RUN;
                else if (smp_valid && col_last)  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // state-derived outputs
    always_comb begin
        busy    = 1'b0;
        smp_acc = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_RUN: begin
                busy    = 1'b1;
                smp_acc = smp_valid && !col_start;
            end
            default: busy = 1'b0;
        endcase
    end

    // column counters and migration offset accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q  <= '0;
            set_q  <= '0;
            acc_q  <= '0;
            step_q <= '0;
        end else if (col_start) begin
            seg_q  <= '0;
            set_q  <= '0;
            acc_q  <= '0;
            step_q <= step_cfg;
        end else if (smp_acc) begin
            acc_q <= acc_q + ACC_W'(step_q);
            if (seg_q == GW'(SEG_LEN - 1)) begin
                seg_q <= '0;
                set_q <= (set_q == SW'(NUM_SETS - 1)) ? '0 : set_q + SW'(1);
            end else begin
                seg_q <= seg_q + GW'(1);
            end
        end
    end

    assign set_idx = set_q;
    assign rd_off  = acc_q[ACC_W-1:FRAC];

    p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(col_start) |-> (state_q == ST_RUN && acc_q == '0 && seg_q == '0 && set_q == '0));

    p_end_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_acc && col_last) |=> (state_q == ST_IDLE));

    p_step_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !col_start) |=> $stable(step_q));

endmodule

// File: rtl/mf_pe_sbuf.sv
module mf_pe_sbuf #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int TAPS  = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [DW-1:0]            wdata,
    input  logic [AW-1:0]            base,
    input  logic [AW-1:0]            off,
    output logic [AW-1:0]            wptr,
    output logic [TAPS-1:0][DW-1:0]  taps
);

    logic [DEPTH-1:0][DW-1:0] mem_q;
    logic [AW-1:0]            wptr_q;
    logic [AW-1:0]            rd_addr [TAPS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q  <= '0;
            wptr_q <= '0;
        end else if (we) begin
            mem_q[wptr_q] <= wdata;
            wptr_q        <= wptr_q + AW'(1);
        end
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign rd_addr[k] = base - off - AW'(k);
        assign taps[k]    = mem_q[rd_addr[k]];
    end

    assign wptr = wptr_q;

    p_wptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (wptr_q == $past(wptr_q) + AW'(1)));

    p_wptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(wptr_q));

endmodule

// File: rtl/mf_pe_cmem.sv
module mf_pe_cmem #(
    parameter int CW       = 16,
    parameter int NUM_SETS = 4,
    parameter int TAPS     = 4,
    localparam int SW      = $clog2(NUM_SETS),
    localparam int TW      = $clog2(TAPS),
    localparam int N       = NUM_SETS * TAPS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     busy,
    input  logic                     we,
    input  logic [SW+TW-1:0]         waddr,
    input  logic [CW-1:0]            wdata,
    input  logic [SW-1:0]            rd_set,
    output logic [TAPS-1:0][CW-1:0]  coefs
);

    logic [N-1:0][CW-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            mem_q <= '0;
        else if (we && !busy)  mem_q[waddr] <= wdata;
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_rd
        assign coefs[k] = mem_q[{rd_set, TW'(k)}];
    end

    p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mem_q));

endmodule

// File: rtl/mf_pe_mac.sv
module mf_pe_mac #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int TAPS = 4,
    localparam int PW  = DW + CW,
    localparam int RW  = PW + $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_v,
    input  logic [TAPS-1:0][DW-1:0]  smp,
    input  logic [TAPS-1:0][CW-1:0]  cf,
    output logic                     res_valid,
    output logic [RW-1:0]            res_data
);

    logic signed [PW-1:0] prod_q [TAPS];
    logic                 prod_v_q;
    logic signed [RW-1:0] sum_c;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_v_q <= 1'b0;
            for (int k = 0; k < TAPS; k++) prod_q[k] <= '0;
        end else begin
            prod_v_q <= in_v;
            if (in_v) begin
                for (int k = 0; k < TAPS; k++)
                    prod_q[k] <= $signed(smp[k]) * $signed(cf[k]);
            end
        end
    end

    always_comb begin
        sum_c = '0;
        for (int k = 0; k < TAPS; k++) sum_c = sum_c + RW'(prod_q[k]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= prod_v_q;
            if (prod_v_q) res_data <= sum_c;
        end
    end

endmodule

// File: rtl/mf_tap_pe.sv
module mf_tap_pe
    import mf_pe_pkg::*;
#(
    parameter int DW       = DEF_DW,
    parameter int CW       = DEF_CW,
    parameter int TAPS     = DEF_TAPS,
    parameter int DEPTH    = DEF_DEPTH,
    parameter int SEG_LEN  = DEF_SEG_LEN,
    parameter int NUM_SETS = DEF_NUM_SETS,
    parameter int FRAC     = DEF_FRAC,
    parameter int STEP_W   = DEF_STEP_W
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        col_start,
    input  logic [STEP_W-1:0]                           step_cfg,
    input  logic                                        smp_valid,
    input  logic [DW-1:0]                               smp_data,
    input  logic                                        coef_we,
    input  logic [$clog2(NUM_SETS)+$clog2(TAPS)-1:0]    coef_addr,
    input  logic [CW-1:0]                               coef_data,
    output logic                                        res_valid,
    output logic [DW+CW+$clog2(TAPS)-1:0]               res_data
);

    localparam int AW = $clog2(DEPTH);
    localparam int SW = $clog2(NUM_SETS);

    logic                      smp_acc, busy;
    logic [SW-1:0]             set_idx;
    logic [AW-1:0]             rd_off, wptr;
    logic                      s1_v_q;
    logic [AW-1:0]             s1_base_q, s1_off_q;
    logic [SW-1:0]             s1_set_q;
    logic [TAPS-1:0][DW-1:0]   tap_smp;
    logic [TAPS-1:0][CW-1:0]   tap_cf;

    mf_pe_ctrl #(
        .SEG_LEN(SEG_LEN), .NUM_SETS(NUM_SETS), .FRAC(FRAC),
        .STEP_W(STEP_W), .AW(AW)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .col_start(col_start), .smp_valid(smp_valid),
        .step_cfg(step_cfg), .smp_acc(smp_acc), .busy(busy),
        .set_idx(set_idx), .rd_off(rd_off)
    );

    mf_pe_sbuf #(.DW(DW), .DEPTH(DEPTH), .TAPS(TAPS)) i_sbuf (
        .clk(clk), .rst_n(rst_n), .we(smp_acc), .wdata(smp_data),
        .base(s1_base_q), .off(s1_off_q), .wptr(wptr), .taps(tap_smp)
    );

    // capture stage: slot written, offset and group of this sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v_q    <= 1'b0;
            s1_base_q <= '0;
            s1_off_q  <= '0;
            s1_set_q  <= '0;
        end else begin
            s1_v_q <= smp_acc;
            if (smp_acc) begin
                s1_base_q <= wptr;
                s1_off_q  <= rd_off;
                s1_set_q  <= set_idx;
            end
        end
    end

    mf_pe_cmem #(.CW(CW), .NUM_SETS(NUM_SETS), .TAPS(TAPS)) i_cmem (
        .clk(clk), .rst_n(rst_n), .busy(busy), .we(coef_we),
        .waddr(coef_addr), .wdata(coef_data), .rd_set(s1_set_q), .coefs(tap_cf)
    );

    mf_pe_mac #(.DW(DW), .CW(CW), .TAPS(TAPS)) i_mac (
        .clk(clk), .rst_n(rst_n), .in_v(s1_v_q), .smp(tap_smp), .cf(tap_cf),
        .res_valid(res_valid), .res_data(res_data)
    );

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == $past(smp_acc, 3));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_data));

    p_idle_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && smp_valid) |=> $stable(wptr));

endmodule

// File: tb/test_mf_tap_pe.sv
module test_mf_tap_pe;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        col_start = 1'b0;
    logic [11:0] step_cfg = '0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        coef_we = 1'b0;
    logic [3:0]  coef_addr = '0;
    logic [15:0] coef_data = '0;
    logic        res_valid;
    logic [33:0] res_data;

    always #5 clk = ~clk;

    mf_tap_pe i_mf_tap_pe (
        .clk(clk), .rst_n(rst_n), .col_start(col_start), .step_cfg(step_cfg),
        .smp_valid(smp_valid), .smp_data(smp_data), .coef_we(coef_we),
        .coef_addr(coef_addr), .coef_data(coef_data),
        .res_valid(res_valid), .res_data(res_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // independent reference state
    logic signed [15:0] m_buf [16];
    logic signed [15:0] m_coef [16];
    int m_wp = 0, m_seg = 0, m_set = 0, m_acc = 0, m_step = 0;
    bit m_busy = 0;

    logic               e_v [1:3];
    logic signed [33:0] e_d [1:3];
    string              e_t [1:3];
    logic signed [33:0] last_d = '0;

    // column stimulus table: step, first sample, sample increment, gap period
    localparam int NV = 4;
    localparam int V_STEP [NV] = '{32'h000, 32'h040, 32'h010, 32'h0FF};
    localparam int V_SEED [NV] = '{100, -500, 32000, 1};
    localparam int V_INC  [NV] = '{3, 7, -1000, 257};
    localparam int V_GAP  [NV] = '{0, 1, 0, 2};
    string v_tag [NV] = '{"R3", "R4", "R6", "R7"};

    task automatic step(input logic v, input logic [15:0] d, input logic cs,
                        input logic [11:0] st, input logic cw, input logic [3:0] ca,
                        input logic [15:0] cd, input string tag);
        int off;
        longint sum;
        logic nv;
        logic signed [33:0] nd;
        @(negedge clk);
        n_chk++;
        if (res_valid !== e_v[3]) begin
            n_bad++;
            $display("FAIL %s res_valid actual=%0b expected=%0b", e_t[3], res_valid, e_v[3]);
        end
        n_chk++;
        if (e_v[3]) begin
            if (res_data !== e_d[3]) begin
                n_bad++;
                $display("FAIL %s res_data actual=%0d expected=%0d", e_t[3],
                         $signed(res_data), e_d[3]);
            end
            last_d = e_d[3];
        end else if (res_data !== last_d) begin
            n_bad++;
            $display("FAIL R11 res_data hold actual=%0d expected=%0d", $signed(res_data), last_d);
        end
        smp_valid = v; smp_data = d; col_start = cs; step_cfg = st;
        coef_we = cw; coef_addr = ca; coef_data = cd;
        nv = 1'b0; nd = '0;
        if (cw && !m_busy) m_coef[ca] = cd;
        if (cs) begin
            m_busy = 1; m_seg = 0; m_set = 0; m_acc = 0; m_step = st;
        end else if (m_busy && v) begin
            off = (m_acc >> 8) & 15;
            m_buf[m_wp] = d;
            sum = 0;
            for (int k = 0; k < 4; k++)
                sum += longint'(m_coef[m_set*4 + k]) * longint'(m_buf[(m_wp - off - k) & 15]);
            nd = sum[33:0];
            nv = 1'b1;
            m_wp = (m_wp + 1) & 15;
            m_acc = (m_acc + m_step) & 32'hFFF;
            if (m_seg == 63) begin
                m_seg = 0;
                if (m_set == 3) begin m_set = 0; m_busy = 0; end
                else m_set++;
            end else m_seg++;
        end
        e_v[3] = e_v[2]; e_d[3] = e_d[2]; e_t[3] = e_t[2];
        e_v[2] = e_v[1]; e_d[2] = e_d[1]; e_t[2] = e_t[1];
        e_v[1] = nv;     e_d[1] = nd;     e_t[1] = tag;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 16'h0, 0, 12'h0, 0, 4'h0, 16'h0, tag);
    endtask

    task automatic load_coefs(input int cfg);
        for (int a = 0; a < 16; a++)
            step(0, 16'h0, 0, 12'h0, 1, 4'(a), 16'(a*1237 + cfg*4099 - 9000), "R7");
    endtask

    // mode: 0 plain, 1 coef write while running, 2 step change, 3 restart, 4 sample with start
    task automatic run_column(input int st, input int seed, input int inc, input int gap,
                              input int mode, input string tag);
        int i = 0;
        int cyc = 0;
        bit restarted = 0;
        logic [11:0] stv;
        step(mode == 4, 16'h7777, 1, 12'(st), 0, 4'h0, 16'h0, tag);
        while (i < 256) begin
            stv = (mode == 2 && i >= 20) ? 12'(st + 12'h123) : 12'(st);
            if (mode == 3 && i == 40 && !restarted) begin
                step(1, 16'h1234, 1, stv, 0, 4'h0, 16'h0, tag);
                restarted = 1;
                i = 0;
            end else if (gap != 0 && (cyc % (gap + 2)) == gap + 1) begin
                step(0, 16'hBEEF, 0, stv, 0, 4'h0, 16'h0, tag);
            end else begin
                step(1, 16'(seed + i*inc), 0, stv, (mode == 1 && i == 10), 4'd12, 16'sd999, tag);
                i++;
            end
            cyc++;
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_buf[i] = '0; m_coef[i] = '0; end
        for (int i = 1; i <= 3; i++) begin e_v[i] = 1'b0; e_d[i] = '0; e_t[i] = "R3"; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (res_valid !== 1'b0 || res_data !== '0) begin
            n_bad++;
            $display("FAIL R1 reset outputs actual=%0b/%0d expected=0/0", res_valid, res_data);
        end
        // R1: zero store and zero ring give zero terms
        run_column(32'h020, 5, 3, 0, 0, "R1");
        for (int t = 0; t < NV; t++) begin
            load_coefs(t);
            run_column(V_STEP[t], V_SEED[t], V_INC[t], V_GAP[t], 0, v_tag[t]);
        end
        idle(3, "R8");
        // R8: samples while idle make no term and stay out of the ring
        for (int i = 0; i < 6; i++) step(1, 16'(-3000 + i), 0, 12'h0, 0, 4'h0, 16'h0, "R8");
        idle(3, "R8");
        run_column(32'h000, 11, 5, 0, 0, "R5");
        run_column(32'h030, -77, 13, 0, 1, "R9");
        run_column(32'h050, 900, -9, 1, 2, "R10");
        run_column(32'h022, 40, 31, 0, 3, "R2");
        run_column(32'h011, -8, 17, 0, 4, "R2");
        idle(6, "R11");
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule